// File: doc/BRIEF.md
# Multi-Channel Tick Timer

This block is a register-mapped timer with a set of down-counting event channels and one free-running 32-bit timestamp counter. A single shared control word holds, for every channel, a timebase selector. For each event channel it also holds a repeat-mode flag and a run flag. Every channel has its own value word. Writing an event channel's value word sets its reload value. Reading it returns the live count.

Software stops a channel by clearing its run flag. It then writes the delay and sets the run flag again, with the repeat flag chosen. Setting the run flag loads the count from the value word. The count then drops by one on each tick of the selected timebase. On the tick where the count is already zero the channel expires and emits a one-clock interrupt pulse. In repeat mode it reloads and keeps running. In single mode it clears its own run flag.

An internal prescaler divides the system clock into a 1 µs tick and a 1 ms tick. Any channel can also count raw system clocks.

Top module: `tmr_tick_unit`

## Requirements
- R1: After reset the control word reads 0, no interrupt bit is high, and every event channel's value word reads 0.
- R2: The control word is at byte offset 0 and channel t's value word is at byte offset (t+1)*4, with the timestamp as channel NUM_EVT. The control word layout is as follows. Event channel t has a 2-bit timebase field at bit 2t. The timestamp has a 3-bit field at bit 2*NUM_EVT. The repeat flag for channel t is at bit 12+t and the run flag at bit 16+t. Undefined bits read as 0, so with 4 channels, writing all ones reads back 0x000FF7FF.
- R3: Setting a run flag that was clear loads the count from the value word. In single mode, a loaded value N expires on the (N+1)th tick, and the channel then clears its own run flag.
- R4: In repeat mode with value N, the channel expires every N+1 ticks and its run flag stays set.
- R5: Each expiry of channel t drives bit t of the interrupt output high for exactly one clock, in the clock after the expiring tick.
- R6: Clearing a run flag stops that channel at once. Its count holds and no interrupt follows.
- R7: Event timebase codes: 0 selects the 1 µs tick, 1 selects the 1 ms tick, and 2 and 3 select the system clock.
- R8: The timestamp is a 32-bit up counter that runs from reset, one step per tick of its timebase. Its codes are 1 for 1 µs, 2 for 1 ms, and any other value for the system clock. Writes to its value word are ignored.
- R9: The 1 µs tick occurs once every US_DIV system clocks, and the 1 ms tick once every MS_DIV microsecond ticks.
- R10: Event delays from 1 to 0xFFFE are accepted and timed exactly.
- R11: Channels time independently when several run at once.
- R12: Reading an event channel's value word returns its current count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; only word-aligned addresses decode |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | NUM_EVT | One-clock expiry pulse per event channel |

## Verification
The assertions assume that software follows the stop, load and start order. They also assume that a channel is never started with a value word of 0 in repeat mode, because that would expire on every tick and blur the one-pulse rule. The stimulus always clears the whole control word before loading a value word. It only starts channels whose delay lies between 1 and 0xFFFE. The one exception is a single readback of an all-ones control word right after reset, which is immediately cleared again.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   localparam int DATA_W      = 32;
   localparam int SEL_W_EVT   = 2;
   localparam int SEL_W_STAMP = 3;
   localparam int PER_BASE    = 12;
   localparam int EN_BASE     = 16;

   typedef enum logic [1:0] {
      TB_SYS = 2'd0,
      TB_US  = 2'd1,
      TB_MS  = 2'd2
   } tbase_e;

   function automatic tbase_e evt_base(input logic [SEL_W_EVT-1:0] code);
      case (code)
         2'd0:    return TB_US;
         2'd1:    return TB_MS;
         default: return TB_SYS;
      endcase
   endfunction

   function automatic tbase_e stamp_base(input logic [SEL_W_STAMP-1:0] code);
      case (code)
         3'd1:    return TB_US;
         3'd2:    return TB_MS;
         default: return TB_SYS;
      endcase
   endfunction

   function automatic logic pick_tick(input tbase_e b, input logic us, input logic ms);
      case (b)
         TB_US:   return us;
         TB_MS:   return ms;
         default: return 1'b1;
      endcase
   endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int US_DIV = 125,
   parameter int MS_DIV = 1000
) (
   input  logic clk,
   input  logic rst_n,
   output logic us_tick_o,
   output logic ms_tick_o
);

   localparam int US_W = (US_DIV > 1) ? $clog2(US_DIV) : 1;
   localparam int MS_W = (MS_DIV > 1) ? $clog2(MS_DIV) : 1;
   localparam logic [US_W-1:0] US_LAST = US_W'(US_DIV - 1);
   localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_DIV - 1);

   generate
      if (US_DIV < 1 || MS_DIV < 1) begin : g_bad_div
         $error("tmr_prescale: dividers must be at least 1");
      end
   endgenerate

   logic [US_W-1:0] us_cnt_q;
   logic [MS_W-1:0] ms_cnt_q;

   assign us_tick_o = (us_cnt_q == US_LAST);
   assign ms_tick_o = us_tick_o && (ms_cnt_q == MS_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         us_cnt_q <= '0;
         ms_cnt_q <= '0;
      end else begin
         us_cnt_q <= us_tick_o ? '0 : us_cnt_q + US_W'(1);
         if (us_tick_o)
            ms_cnt_q <= (ms_cnt_q == MS_LAST) ? '0 : ms_cnt_q + MS_W'(1);
      end
   end

   // R9
   ms_in_us_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ms_tick_o |-> us_tick_o);

   generate
      if (US_DIV > 1) begin : g_gap
         // R9
         us_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            us_tick_o |=> !us_tick_o);
      end
   endgenerate

endmodule

// File: rtl/tmr_evt_chan.sv
module tmr_evt_chan #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             en_i,
   input  logic             periodic_i,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic             wr_i,
   input  logic [CNT_W-1:0] wdata_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             expire_o,
   output logic             irq_o
);

   logic [CNT_W-1:0] reload_q;
   logic [CNT_W-1:0] cnt_q;
   logic             irq_q;
   logic             active;

   assign active   = en_i && !stop_i;
   assign expire_o = active && tick_i && (cnt_q == '0);
   assign cnt_o    = cnt_q;
   assign irq_o    = irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         reload_q <= '0;
      else if (wr_i)
         reload_q <= wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         irq_q <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (start_i) begin
            cnt_q <= reload_q;
         end else if (active && tick_i) begin
            if (cnt_q == '0) begin
               irq_q <= 1'b1;
               if (periodic_i)
                  cnt_q <= reload_q;
            end else begin
               cnt_q <= cnt_q - CNT_W'(1);
            end
         end
      end
   end

   // R3
   start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (cnt_o == $past(reload_q)));

   // R6
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !start_i) |=> $stable(cnt_o));

   // R5
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(en_i && tick_i));

endmodule

// File: rtl/tmr_stamp.sv
module tmr_stamp #(
   parameter int STAMP_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_i,
   output logic [STAMP_W-1:0] cnt_o
);

   logic [STAMP_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (tick_i)
         cnt_q <= cnt_q + STAMP_W'(1);
   end

   assign cnt_o = cnt_q;

   // R8
   stamp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i |=> (cnt_o == $past(cnt_o) + STAMP_W'(1)));

   // R8
   stamp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(cnt_o));

endmodule

// File: rtl/tmr_tick_unit.sv
module tmr_tick_unit #(
   parameter int NUM_EVT = 4,
   parameter int CNT_W   = 16,
   parameter int US_DIV  = 125,
   parameter int MS_DIV  = 1000,
   parameter int ADDR_W  = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic [NUM_EVT-1:0] irq
);
   import tmr_pkg::*;

   localparam int WORD_W    = ADDR_W - 2;
   localparam int STAMP_IDX = NUM_EVT;
   localparam int STAMP_LSB = SEL_W_EVT * NUM_EVT;

   function automatic logic [DATA_W-1:0] ctrl_mask();
      logic [DATA_W-1:0] m;
      m = '0;
      for (int i = 0; i < NUM_EVT; i++) begin
         m[SEL_W_EVT*i]     = 1'b1;
         m[SEL_W_EVT*i + 1] = 1'b1;
         m[PER_BASE + i]    = 1'b1;
         m[EN_BASE + i]     = 1'b1;
      end
      for (int j = 0; j < SEL_W_STAMP; j++)
         m[STAMP_LSB + j] = 1'b1;
      return m;
   endfunction

   localparam logic [DATA_W-1:0] CTRL_MASK = ctrl_mask();

   generate
      if (NUM_EVT < 1 || NUM_EVT > 4) begin : g_bad_n
         $error("tmr_tick_unit: NUM_EVT must be 1 to 4");
      end
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_w
         $error("tmr_tick_unit: CNT_W must be 2 to 32");
      end
      if ((1 << WORD_W) < NUM_EVT + 2) begin : g_bad_a
         $error("tmr_tick_unit: ADDR_W too small for the register map");
      end
   endgenerate

   logic                us_tick, ms_tick;
   logic [DATA_W-1:0]   ctrl_q, ctrl_d;
   logic [WORD_W-1:0]   word;
   logic                aligned, ctrl_wr;
   logic [NUM_EVT-1:0]  expire, clr_en;
   logic [CNT_W-1:0]    evt_cnt [NUM_EVT];
   logic [31:0]         stamp_cnt;
   logic                stamp_tick;

   assign word    = bus_addr[ADDR_W-1:2];
   assign aligned = (bus_addr[1:0] == 2'b00);
   assign ctrl_wr = bus_wr && aligned && (word == '0);

   tmr_prescale #(
      .US_DIV (US_DIV),
      .MS_DIV (MS_DIV)
   ) u_prescale (
      .clk       (clk),
      .rst_n     (rst_n),
      .us_tick_o (us_tick),
      .ms_tick_o (ms_tick)
   );

   generate
      for (genvar t = 0; t < NUM_EVT; t++) begin : g_chan
         logic en, per, start, stop, wr_val, tick;
         logic [SEL_W_EVT-1:0] sel;

         assign sel    = ctrl_q[SEL_W_EVT*t +: SEL_W_EVT];
         assign en     = ctrl_q[EN_BASE + t];
         assign per    = ctrl_q[PER_BASE + t];
         assign tick   = pick_tick(evt_base(sel), us_tick, ms_tick);
         assign start  = ctrl_wr && bus_wdata[EN_BASE + t] && !en;
         assign stop   = ctrl_wr && !bus_wdata[EN_BASE + t];
         assign wr_val = bus_wr && aligned && (word == WORD_W'(t + 1));
         assign clr_en[t] = expire[t] && !per;

         tmr_evt_chan #(
            .CNT_W (CNT_W)
         ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick_i     (tick),
            .en_i       (en),
            .periodic_i (per),
            .start_i    (start),
            .stop_i     (stop),
            .wr_i       (wr_val),
            .wdata_i    (bus_wdata[CNT_W-1:0]),
            .cnt_o      (evt_cnt[t]),
            .expire_o   (expire[t]),
            .irq_o      (irq[t])
         );

         // R3
         oneshot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (expire[t] && !per && !ctrl_wr) |=> !ctrl_q[EN_BASE + t]);

         // R4
         repeat_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (expire[t] && per && !ctrl_wr) |=> ctrl_q[EN_BASE + t]);
      end
   endgenerate

   assign stamp_tick = pick_tick(stamp_base(ctrl_q[STAMP_LSB +: SEL_W_STAMP]),
                                 us_tick, ms_tick);

   tmr_stamp #(
      .STAMP_W (32)
   ) u_stamp (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (stamp_tick),
      .cnt_o  (stamp_cnt)
   );

   always_comb begin
      ctrl_d = ctrl_q;
      if (ctrl_wr) begin
         ctrl_d = bus_wdata & CTRL_MASK;
      end else begin
         for (int i = 0; i < NUM_EVT; i++)
            if (clr_en[i]) ctrl_d[EN_BASE + i] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= '0;
      else
         ctrl_q <= ctrl_d;
   end

   always_comb begin
      bus_rdata = '0;
      if (aligned) begin
         if (word == '0)
            bus_rdata = ctrl_q;
         else if (word == WORD_W'(STAMP_IDX + 1))
            bus_rdata = stamp_cnt;
         for (int i = 0; i < NUM_EVT; i++)
            if (word == WORD_W'(i + 1))
               bus_rdata = 32'(evt_cnt[i]);
      end
   end

   // R2
   ctrl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q & ~CTRL_MASK) == '0);

endmodule

// File: tb/tmr_tick_unit_bench.sv
module tmr_tick_unit_bench;

   localparam int NE     = 4;
   localparam int US_DIV = 4;
   localparam int MS_DIV = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [4:0]    bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NE-1:0] irq;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   tmr_tick_unit #(
      .NUM_EVT (NE),
      .CNT_W   (16),
      .US_DIV  (US_DIV),
      .MS_DIV  (MS_DIV),
      .ADDR_W  (5)
   ) u_tmr_tick_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wait_irq(input int ch, input int limit, output int k);
      k = 0;
      while (irq[ch] !== 1'b1 && k < limit) begin
         @(negedge clk);
         k++;
      end
   endtask

   task automatic gap(input int ch, input int limit, output int g);
      int k;
      @(negedge clk);
      chk("R5", "pulse lasts one clock", {31'd0, irq[ch]}, 32'd0);
      wait_irq(ch, limit, k);
      g = k + 1;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(5'd0, d);
      chk("R1", "control after reset", d, 32'd0);
      chk("R1", "irq after reset", {28'd0, irq}, 32'd0);
      rd(5'd4, d);
      chk("R1", "ch0 count after reset", d, 32'd0);
   endtask

   task automatic t_map();
      logic [31:0] d;
      wr(5'd0, 32'hFFFF_FFFF);
      rd(5'd0, d);
      chk("R2", "control readback mask", d, 32'h000F_F7FF);
      wr(5'd0, 32'd0);
      wr(5'd12, 32'd77);
      rd(5'd12, d);
      chk("R2", "ch2 value word at offset 12 idle", d, 32'd0);
   endtask

   task automatic t_oneshot();
      logic [31:0] d;
      int k;
      wr(5'd0, 32'd0);
      wr(5'd4, 32'd3);
      wr(5'd0, 32'h0001_0002);
      wait_irq(0, 100, k);
      chk("R3", "single expiry after N+1 ticks", k, 32'd4);
      @(negedge clk);
      chk("R5", "single pulse one clock", {31'd0, irq[0]}, 32'd0);
      rd(5'd0, d);
      chk("R3", "run flag self-clears", d, 32'h0000_0002);
      repeat (10) @(negedge clk);
      chk("R3", "no second expiry", {31'd0, irq[0]}, 32'd0);
   endtask

   task automatic t_bounds();
      int k;
      wr(5'd0, 32'd0);
      wr(5'd4, 32'd1);
      wr(5'd0, 32'h0001_0003);
      wait_irq(0, 100, k);
      chk("R10", "delay 1", k, 32'd2);
      wr(5'd0, 32'd0);
      wr(5'd4, 32'h0000_FFFE);
      wr(5'd0, 32'h0001_0002);
      wait_irq(0, 70000, k);
      chk("R10", "delay 0xFFFE", k, 32'd65535);
   endtask

   task automatic t_repeat();
      logic [31:0] d;
      int k, g;
      wr(5'd0, 32'd0);
      wr(5'd8, 32'd3);
      wr(5'd0, 32'h0002_200C);
      wait_irq(1, 100, k);
      chk("R4", "first repeat expiry", k, 32'd4);
      gap(1, 100, g);
      chk("R4", "repeat period", g, 32'd4);
      gap(1, 100, g);
      chk("R4", "repeat period again", g, 32'd4);
      rd(5'd0, d);
      chk("R4", "run flag kept", d, 32'h0002_200C);
   endtask

   task automatic t_bases();
      int k, g;
      wr(5'd0, 32'd0);
      wr(5'd4, 32'd2);
      wr(5'd0, 32'h0001_1000);
      wait_irq(0, 200, k);
      gap(0, 200, g);
      chk("R7", "code 0 is 1us base (R9 divider)", g, 32'(3 * US_DIV));
      wr(5'd0, 32'd0);
      wr(5'd4, 32'd1);
      wr(5'd0, 32'h0001_1001);
      wait_irq(0, 500, k);
      gap(0, 500, g);
      chk("R7", "code 1 is 1ms base (R9 divider)", g, 32'(2 * US_DIV * MS_DIV));
      wr(5'd0, 32'd0);
   endtask

   task automatic t_stop();
      logic [31:0] c1, c2;
      int hits;
      wr(5'd0, 32'd0);
      wr(5'd8, 32'd5);
      wr(5'd0, 32'h0002_2008);
      @(negedge clk);
      wr(5'd0, 32'd0);
      rd(5'd8, c1);
      hits = 0;
      repeat (20) begin
         @(negedge clk);
         if (irq[1]) hits++;
      end
      rd(5'd8, c2);
      chk("R6", "no irq after stop", hits, 32'd0);
      chk("R6", "count holds after stop", c2, c1);
   endtask

   task automatic t_readcnt();
      logic [31:0] d;
      wr(5'd0, 32'd0);
      wr(5'd4, 32'd100);
      wr(5'd0, 32'h0001_0002);
      rd(5'd4, d);
      chk("R12", "count loaded", d, 32'd100);
      repeat (10) @(negedge clk);
      rd(5'd4, d);
      chk("R12", "count after 10 ticks", d, 32'd90);
      wr(5'd0, 32'd0);
   endtask

   task automatic t_indep();
      int n2, n3;
      wr(5'd0, 32'd0);
      wr(5'd12, 32'd3);
      wr(5'd16, 32'd6);
      wr(5'd0, 32'h000C_C0A0);
      n2 = 0;
      n3 = 0;
      repeat (28) begin
         @(negedge clk);
         if (irq[2]) n2++;
         if (irq[3]) n3++;
      end
      chk("R11", "ch2 pulses in 28 clocks", n2, 32'd7);
      chk("R11", "ch3 pulses in 28 clocks", n3, 32'd4);
      wr(5'd0, 32'd0);
   endtask

   task automatic t_stamp();
      logic [31:0] a, b;
      wr(5'd0, 32'd0);
      rd(5'd20, a);
      wr(5'd20, 32'd0);
      rd(5'd20, b);
      chk("R8", "write ignored, sysclk steps", b - a, 32'd2);
      wr(5'd0, 32'h0000_0100);
      rd(5'd20, a);
      repeat (40) @(negedge clk);
      rd(5'd20, b);
      chk("R8", "1us base steps", b - a, 32'd10);
      wr(5'd0, 32'h0000_0200);
      rd(5'd20, a);
      repeat (120) @(negedge clk);
      rd(5'd20, b);
      chk("R8", "1ms base steps", b - a, 32'd10);
      wr(5'd0, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_map();
      t_oneshot();
      t_bounds();
      t_repeat();
      t_bases();
      t_stop();
      t_readcnt();
      t_indep();
      t_stamp();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule